// File: doc/BRIEF.md
# Shader Flow-Control Sequencer

This block is the program-counter unit of a small shader core. Each cycle it reads the instruction word fetched at its current PC. It carries out the flow-control instructions among them and lets every other opcode fall through to PC + 1. The supported instructions are calls (plain, flag-conditional and uniform-gated), two-way branches, counted loops, jumps and the program end. It keeps a small hardware stack of control entries, and one entry format serves calls, branch bodies and loops. Before each fetch it compares the PC with the end address of the top entry and unwinds or repeats as required. It also keeps an 8-bit loop-counter register that loops load and step.

The block has three states. IDLE is the state after reset. A `start` pulse moves it from IDLE or FINISHED to RUN: the PC is loaded from `entry_pc`, and the stack, the loop counter and the overflow flag are cleared. In RUN there are two kinds of cycle. In an unwind cycle the PC sits on the top entry's end address, and the cycle is spent on the stack. In an execute cycle the word at the PC is decoded. Executing the end opcode moves RUN to FINISHED. FINISHED holds the PC until the next `start`. A `start` seen while in RUN is ignored.

Top module: `sfc_seq`

## Requirements
- R1: After reset the block is idle with pc, loop_reg, done and overflow all zero. A start pulse from idle or finished loads pc with entry_pc, zeroes loop_reg, clears overflow, empties the stack and sets busy from the next cycle.
- R2: Conditional opcodes take bits 25 (x reference), 24 (y reference) and 23:22 (combine op). x_ok is (x reference == cond_x) and y_ok is (y reference == cond_y). Combine op 0 gives x_ok OR y_ok, 1 gives AND, 2 gives x_ok alone and 3 gives y_ok alone. Uniform-gated opcodes test bool_unif[bits 25:22].
- R3: When the stack is not empty and pc equals the top entry's end address, no instruction is executed in that cycle, and loop_reg gains the top entry's increment.
- R4: In such an unwind cycle, a repeat count of zero pops the entry and sends pc to its return address. Any other repeat count is decremented and sends pc back to the entry's start address.
- R5: Opcode 0x24 (call), 0x25 (flag call) and 0x26 (uniform call) take bits 21:10 as destination and bits 7:0 as count. When taken, each pushes an entry ending at destination + count that returns to pc + 1, and sets pc to the destination. A call not taken goes to pc + 1.
- R6: Opcode 0x27 (uniform branch) and 0x28 (flag branch), when true, continue at pc + 1 with an entry ending at the destination. When false they continue at the destination with an entry ending at destination + count. In both cases the entry returns to destination + count.
- R7: Opcode 0x29 (loop) reads integer uniform bits 23:22, packed x = bits 7:0, y = 15:8, z = 23:16 within each 24-bit slot of int_unif. It sets loop_reg to y and continues at pc + 1. It pushes an entry with repeat x, increment z and end/return at destination + 1, so the body runs x + 1 times.
- R8: Opcode 0x2C (flag jump) and 0x2D (uniform jump) set pc to the destination when taken and to pc + 1 otherwise. They leave the stack unchanged.
- R9: Opcode 0x22 (end) stops execution. done rises and busy falls in the next cycle, and pc keeps the address of the end word until the next start.
- R10: A push onto a full stack is dropped and sets a sticky overflow flag; the PC still moves as for a successful push.
- R11: At most one entry is resolved per cycle, so entries whose end addresses meet after a return unwind on successive cycles.
- R12: Any opcode that is not a flow-control code (for example 0x01 or NOP 0x21) advances pc by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a program at entry_pc |
| entry_pc | input | 12 | First instruction address |
| instr | input | 32 | Instruction word at the current pc |
| bool_unif | input | 16 | Boolean uniforms |
| int_unif | input | 96 | Four integer uniforms, 24 bits each (x, y, z) |
| cond_x | input | 1 | First condition flag |
| cond_y | input | 1 | Second condition flag |
| pc | output | 12 | Current program counter / fetch address |
| loop_reg | output | 8 | Loop-counter register |
| busy | output | 1 | RUN state |
| done | output | 1 | FINISHED state |
| overflow | output | 1 | Sticky stack overflow |

## Verification
The PC trace is checked cycle by cycle for six programs, each built to separate one kind of behaviour. The first is a call returning into a taken uniform jump, with an arithmetic opcode in the body. The second is a three-pass loop, which shows whether repeats return to the body start and whether the increment lands once per pass. The third mixes flag branches, calls and jumps under several combine ops, so each op and both reference polarities take or skip a path. The fourth ends with a call whose return lands on the outer entry's end address, which exposes double unwinding in one cycle. The last two overfill the stack and then run a false uniform branch, which shows the dropped push, the sticky flag and its clearing on the next start.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int ADDR_W = 12;
    localparam int CNT_W  = 8;
    localparam int OP_W   = 6;

    localparam logic [OP_W-1:0] OP_NOP   = 6'h21;
    localparam logic [OP_W-1:0] OP_END   = 6'h22;
    localparam logic [OP_W-1:0] OP_CALL  = 6'h24;
    localparam logic [OP_W-1:0] OP_CALLC = 6'h25;
    localparam logic [OP_W-1:0] OP_CALLU = 6'h26;
    localparam logic [OP_W-1:0] OP_IFU   = 6'h27;
    localparam logic [OP_W-1:0] OP_IFC   = 6'h28;
    localparam logic [OP_W-1:0] OP_LOOP  = 6'h29;
    localparam logic [OP_W-1:0] OP_JMPC  = 6'h2C;
    localparam logic [OP_W-1:0] OP_JMPU  = 6'h2D;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FINISHED} state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] end_addr;
        logic [ADDR_W-1:0] ret_addr;
        logic [CNT_W-1:0]  repeat_cnt;
        logic [CNT_W-1:0]  incr;
        logic [ADDR_W-1:0] body_start;
    } frame_t;
endpackage

// File: rtl/sfc_cond.sv
module sfc_cond (
    input  logic       ref_x,
    input  logic       ref_y,
    input  logic [1:0] combine,
    input  logic       flag_x,
    input  logic       flag_y,
    output logic       taken
);
    logic x_ok, y_ok;
    assign x_ok = (ref_x == flag_x);
    assign y_ok = (ref_y == flag_y);

    always_comb begin
        unique case (combine)
            2'd0: taken = x_ok | y_ok;
            2'd1: taken = x_ok & y_ok;
            2'd2: taken = x_ok;
            default: taken = y_ok;
        endcase
    end
endmodule

// File: rtl/sfc_stack.sv
module sfc_stack
    import sfc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int SP_W  = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            push,
    input  frame_t          push_frame,
    input  logic            pop,
    input  logic            dec,
    output frame_t          top,
    output logic            empty,
    output logic            full,
    output logic [SP_W-1:0] level
);
    frame_t           frames_q [DEPTH];
    logic [SP_W-1:0]  sp_q;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;

    assign empty   = (sp_q == '0);
    assign full    = (sp_q == SP_W'(DEPTH));
    assign level   = sp_q;
    assign top_idx = IDX_W'(sp_q - 1'b1);
    assign wr_idx  = IDX_W'(sp_q);
    assign top     = frames_q[top_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sp_q <= '0;
        else if (clear)
            sp_q <= '0;
        else if (push && !full)
            sp_q <= sp_q + 1'b1;
        else if (pop && !empty)
            sp_q <= sp_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!clear && push && !full)
            frames_q[wr_idx] <= push_frame;
        else if (!clear && dec && !empty)
            frames_q[top_idx].repeat_cnt <= frames_q[top_idx].repeat_cnt - 1'b1;
    end

    assert_full_push_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clear) |=> (sp_q == $past(sp_q)));
    assert_single_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clear && !empty) |=> (sp_q == $past(sp_q) - 1'b1));
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
    import sfc_pkg::*;
#(
    parameter int STACK_DEPTH = 4,
    parameter int N_INT       = 4,
    localparam int BOOL_N     = 16,
    localparam int INT_SLOT   = 3 * CNT_W,
    localparam int SP_W       = $clog2(STACK_DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [ADDR_W-1:0]         entry_pc,
    input  logic [31:0]               instr,
    input  logic [BOOL_N-1:0]         bool_unif,
    input  logic [N_INT*INT_SLOT-1:0] int_unif,
    input  logic                      cond_x,
    input  logic                      cond_y,
    output logic [ADDR_W-1:0]         pc,
    output logic [CNT_W-1:0]          loop_reg,
    output logic                      busy,
    output logic                      done,
    output logic                      overflow
);
    state_e             state_q, state_d;
    logic [ADDR_W-1:0]  pc_q, pc_d;
    logic [CNT_W-1:0]   loop_q, loop_d;
    logic               ovf_q, ovf_d;

    logic [OP_W-1:0]    opcode;
    logic [ADDR_W-1:0]  dest, dest_end, pc_inc;
    logic [CNT_W-1:0]   count;
    logic [3:0]         bool_idx;
    logic [1:0]         int_idx;
    logic [INT_SLOT-1:0] int_sel;
    logic               flag_ok, unif_ok;

    frame_t             top, push_frame;
    logic               empty, full, push, pop, dec, clear;
    logic [SP_W-1:0]    level;
    logic               resolve, exec, launch;

    assign opcode   = instr[31:26];
    assign dest     = instr[21:10];
    assign count    = instr[7:0];
    assign bool_idx = instr[25:22];
    assign int_idx  = instr[23:22];
    assign int_sel  = int_unif[int_idx*INT_SLOT +: INT_SLOT];
    assign dest_end = dest + ADDR_W'(count);
    assign pc_inc   = pc_q + 1'b1;
    assign unif_ok  = bool_unif[bool_idx];

    sfc_cond u_cond (
        .ref_x  (instr[25]),
        .ref_y  (instr[24]),
        .combine(instr[23:22]),
        .flag_x (cond_x),
        .flag_y (cond_y),
        .taken  (flag_ok)
    );

    sfc_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .push      (push),
        .push_frame(push_frame),
        .pop       (pop),
        .dec       (dec),
        .top       (top),
        .empty     (empty),
        .full      (full),
        .level     (level)
    );

    assign launch  = start && (state_q != ST_RUN);
    assign resolve = (state_q == ST_RUN) && !empty && (pc_q == top.end_addr);
    assign exec    = (state_q == ST_RUN) && !resolve;

    // Next-state and datapath decisions
    always_comb begin
        state_d    = state_q;
        pc_d       = pc_q;
        loop_d     = loop_q;
        ovf_d      = ovf_q;
        push       = 1'b0;
        pop        = 1'b0;
        dec        = 1'b0;
        clear      = 1'b0;
        push_frame = '{end_addr: dest_end, ret_addr: pc_inc, repeat_cnt: '0,
                       incr: '0, body_start: dest};
        unique case (state_q)
            ST_IDLE, ST_FINISHED: begin
                if (launch) begin
                    state_d = ST_RUN;
                    pc_d    = entry_pc;
                    loop_d  = '0;
                    ovf_d   = 1'b0;
                    clear   = 1'b1;
                end
            end
            ST_RUN: begin
                if (resolve) begin
                    loop_d = loop_q + top.incr;
                    if (top.repeat_cnt == '0) begin
                        pop  = 1'b1;
                        pc_d = top.ret_addr;
                    end else begin
                        dec  = 1'b1;
                        pc_d = top.body_start;
                    end
                end else begin
                    pc_d = pc_inc;
                    if (opcode == OP_END) begin
                        state_d = ST_FINISHED;
                        pc_d    = pc_q;
                    end else if (opcode == OP_CALL ||
                                 (opcode == OP_CALLC && flag_ok) ||
                                 (opcode == OP_CALLU && unif_ok)) begin
                        push = 1'b1;
                        pc_d = dest;
                    end else if (opcode == OP_IFU || opcode == OP_IFC) begin
                        push = 1'b1;
                        push_frame.ret_addr = dest_end;
                        if ((opcode == OP_IFU) ? unif_ok : flag_ok) begin
                            push_frame.end_addr   = dest;
                            push_frame.body_start = pc_inc;
                        end else begin
                            pc_d = dest;
                        end
                    end else if (opcode == OP_LOOP) begin
                        push   = 1'b1;
                        loop_d = int_sel[2*CNT_W-1:CNT_W];
                        push_frame = '{end_addr: dest + 1'b1, ret_addr: dest + 1'b1,
                                       repeat_cnt: int_sel[CNT_W-1:0],
                                       incr: int_sel[3*CNT_W-1:2*CNT_W],
                                       body_start: pc_inc};
                    end else if ((opcode == OP_JMPC && flag_ok) ||
                                 (opcode == OP_JMPU && unif_ok)) begin
                        pc_d = dest;
                    end
                    if (push && full)
                        ovf_d = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            loop_q  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            loop_q  <= loop_d;
            ovf_q   <= ovf_d;
        end
    end

    // Outputs
    always_comb begin
        pc       = pc_q;
        loop_reg = loop_q;
        busy     = (state_q == ST_RUN);
        done     = (state_q == ST_FINISHED);
        overflow = ovf_q;
    end

    assert_launch_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (busy && pc == $past(entry_pc) && loop_reg == '0 && !overflow));
    assert_unwind_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resolve |=> (loop_reg == CNT_W'($past(loop_q) + $past(top.incr))));
    assert_unwind_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve && top.repeat_cnt == '0) |=> (pc == $past(top.ret_addr)));
    assert_jump_keeps_stack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && (opcode == OP_JMPC || opcode == OP_JMPU)) |=> $stable(level));
    assert_end_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && opcode == OP_END) |=> (done && !busy && $stable(pc)));
    assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !launch) |=> overflow);
endmodule

// File: tb/sfc_seq_bench.sv
module sfc_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] entry_pc = '0;
    logic [31:0] instr;
    logic [15:0] bool_unif = 16'h0001;
    logic [95:0] int_unif = '0;
    logic        cond_x = 1'b0;
    logic        cond_y = 1'b0;
    logic [11:0] pc;
    logic [7:0]  loop_reg;
    logic        busy, done, overflow;

    logic [31:0] mem [64];
    int          checks = 0;
    int          errors = 0;
    int          exp_q[$];
    string       cur_tag = "R1";

    always #5 clk = ~clk;

    assign instr = mem[pc[5:0]];

    sfc_seq u_sfc_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .entry_pc(entry_pc),
        .instr(instr), .bool_unif(bool_unif), .int_unif(int_unif),
        .cond_x(cond_x), .cond_y(cond_y), .pc(pc), .loop_reg(loop_reg),
        .busy(busy), .done(done), .overflow(overflow)
    );

    function automatic logic [31:0] enc(input logic [5:0] op, input logic [3:0] sel,
                                        input logic [11:0] dst, input logic [7:0] cnt);
        return {op, sel, dst, 2'b00, cnt};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: compares every busy-cycle pc against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && busy) begin
            if (exp_q.size() == 0) begin
                check({cur_tag, " unexpected extra pc"}, pc, -1);
            end else begin
                check({cur_tag, " pc trace"}, pc, exp_q.pop_front());
            end
        end
    end

    task automatic run_prog(input string tag, input int entry, input int exp_loop,
                            input int exp_ovf);
        cur_tag = tag;
        @(negedge clk);
        entry_pc = 12'(entry);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check({tag, " trace consumed"}, exp_q.size(), 0);
        check({tag, " loop_reg"}, loop_reg, exp_loop);
        check({tag, " overflow"}, overflow, exp_ovf);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = enc(6'h21, 4'd0, 12'd0, 8'd0);
        // Program A: call + uniform jump + arithmetic op (R5, R8, R12, R3, R4)
        mem[0]  = enc(6'h24, 4'd0, 12'd10, 8'd2);
        mem[1]  = enc(6'h2D, 4'd0, 12'd5, 8'd0);
        mem[5]  = enc(6'h22, 4'd0, 12'd0, 8'd0);
        mem[10] = enc(6'h01, 4'd0, 12'd0, 8'd0);
        // Program B: loop x=2 y=5 z=3 (R7, R3, R4)
        mem[20] = enc(6'h29, 4'd1, 12'd22, 8'd0);
        mem[23] = enc(6'h22, 4'd0, 12'd0, 8'd0);
        // Program C: flag branches, call, jumps with cond_x=1 cond_y=0 (R2, R5, R6, R8)
        mem[30] = enc(6'h28, {1'b1, 1'b0, 2'd1}, 12'd33, 8'd2);
        mem[35] = enc(6'h25, {1'b1, 1'b1, 2'd1}, 12'd50, 8'd1);
        mem[36] = enc(6'h28, {1'b0, 1'b1, 2'd3}, 12'd38, 8'd1);
        mem[39] = enc(6'h2C, {1'b0, 1'b1, 2'd0}, 12'd41, 8'd0);
        mem[40] = enc(6'h2C, {1'b1, 1'b0, 2'd2}, 12'd42, 8'd0);
        mem[42] = enc(6'h22, 4'd0, 12'd0, 8'd0);
        // Program D: successive unwinding (R11)
        mem[44] = enc(6'h24, 4'd0, 12'd46, 8'd2);
        mem[45] = enc(6'h22, 4'd0, 12'd0, 8'd0);
        mem[47] = enc(6'h24, 4'd0, 12'd50, 8'd1);
        // Program E: overflow with depth 4 (R10)
        for (int a = 52; a < 57; a++) mem[a] = enc(6'h24, 4'd0, 12'(a + 1), 8'd5);
        mem[57] = enc(6'h22, 4'd0, 12'd0, 8'd0);
        // Program F: false uniform branch (R6), overflow cleared on start (R1)
        mem[60] = enc(6'h27, 4'd1, 12'd62, 8'd1);
        mem[63] = enc(6'h22, 4'd0, 12'd0, 8'd0);

        int_unif[47:24] = 24'h030502;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset pc", pc, 0);
        check("R1 reset busy", busy, 0);
        check("R1 reset done", done, 0);
        check("R1 reset loop_reg", loop_reg, 0);
        check("R1 reset overflow", overflow, 0);

        exp_q = '{0, 10, 11, 12, 1, 5};
        run_prog("R5 R8 R12 call/ujump", 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        check("R9 pc held after end", pc, 5);
        check("R9 done held", done, 1);

        exp_q = '{20, 21, 22, 23, 21, 22, 23, 21, 22, 23, 23};
        run_prog("R7 R3 R4 loop", 20, 14, 0);

        cond_x = 1'b1;
        cond_y = 1'b0;
        exp_q = '{30, 31, 32, 33, 35, 36, 38, 39, 39, 40, 42};
        run_prog("R2 R6 R8 flags", 30, 0, 0);

        exp_q = '{44, 46, 47, 50, 51, 48, 45};
        run_prog("R11 unwind", 44, 0, 0);

        exp_q = '{52, 53, 54, 55, 56, 57};
        run_prog("R10 overflow", 52, 0, 1);

        exp_q = '{60, 62, 63, 63};
        run_prog("R6 R1 else path", 60, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule